// File: doc/BRIEF.md
# I2C Target Port with CPU Register Window

This block is a 7-bit-address I2C target (slave) that sits next to a small processor. Both bus lines are open-drain. They are modelled as a sampled input plus a pull-low enable for each line. The block watches the bus for START and STOP. After a START it collects the calling address and compares it with an address that software programs. On a match it acknowledges, latches the direction bit and raises an interrupt. It then holds SCL low until the processor services a one-byte data register. The same exchange happens after every data byte that the bus continues with: interrupt, clock hold, data-register access, release.

Software reads status to see whether the interrupt came from an address match or from a finished byte. It then sets the data direction (send or take bytes) and the acknowledge value it wants to return. In the sending direction, a write to the data register both supplies the byte and releases the clock. In the taking direction, a dummy read of the data register releases the clock.

Register window (2-bit offset):
- offset 0 holds the own address in bits 6:0.
- offset 1 is control: bit 0 selects sending, bit 1 is the acknowledge value to return.
- offset 2 is status.
- offset 3 is data.

Top module: `i2c_target_ctrl`

## Requirements
- R1: SDA falling while SCL is high sets the busy flag (status bit 0). SDA rising while SCL is high clears it, returns the engine to idle and releases both lines.
- R2: The first 7 bits after START, MSB first, are compared with offset 0 bits 6:0. On a match the block pulls SDA low for the 9th clock. On a mismatch it pulls neither line, raises no interrupt and ignores the bus until the next START or STOP.
- R3: On a match, the 8th bit is stored in the direction flag (status bit 2, 1 = master reads). The address-hit flag (status bit 1) is set and `irq` is raised, all by the end of the 9th clock.
- R4: After the address acknowledge, and after each data byte the bus continues with, SCL is held low. It stays low until the data register (offset 3) is read or written. That access releases SCL and clears `irq`.
- R5: The address-hit flag clears at the access that starts the first data byte.
- R6: With control bit 0 = 0, data bytes are shifted in MSB first and placed in the data register. On the 9th clock the block drives control bit 1 (0 = acknowledge, SDA low). With control bit 1 = 1 the clock is not held after that byte.
- R7: With control bit 0 = 1, the byte written to the data register is driven MSB first. The master's 9th-bit SDA level is stored in status bit 3 (0 = acknowledged). On a not-acknowledge SDA stays released and SCL is not held.
- R8: `irq` is raised at the end of every completed data byte, with the address-hit flag reading 0.
- R9: The SDA pull enable changes only while the sampled SCL is low.
- R10: After reset both pull enables and `irq` are 0, status reads 0 and the own address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull | output | 1 | 1 pulls SDA low |
| cpu_addr | input | 2 | Register offset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (side effect on offset 3) |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench calls the block with a matching write address, a matching read address and a non-matching address. These show that acknowledge, direction capture and the interrupt follow only a match. The master-write pattern sends two distinct bytes, one acknowledged and one refused through the control bit. This separates clock hold on a continued byte from no hold after a refused one. The master-read pattern returns an acknowledge and then a not-acknowledge, which checks both the stored acknowledge flag and the release of SDA. Reading status at each interrupt shows whether the address-hit flag correctly tells the first interrupt from the byte interrupts.

// File: rtl/i2cs_pkg.sv
// Package: shared types and register offsets for the I2C target port.
// Assumes a 2-bit register offset and an 8-bit register window.
package i2cs_pkg;

    // Engine states of the bit-level sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or not yet started
        ST_ADDR,   // collecting address byte
        ST_AACK,   // driving address acknowledge
        ST_HOLD,   // clock held, waiting for data register access
        ST_DATA,   // shifting a data byte
        ST_DACK,   // acknowledge bit of a data byte
        ST_SKIP    // not addressed or transfer ended, wait for START/STOP
    } eng_state_t;

    localparam logic [1:0] OFS_OWN  = 2'd0;
    localparam logic [1:0] OFS_CTRL = 2'd1;
    localparam logic [1:0] OFS_STAT = 2'd2;
    localparam logic [1:0] OFS_DATA = 2'd3;

endpackage

// File: rtl/i2cs_line_sync.sv
// Module: resynchronises SCL and SDA into the system clock domain and
// derives clock edges and START/STOP events from the synchronised levels.
// Assumes the bus is much slower than clk; both lines reset to idle-high.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // Edge and bus-condition decode on synchronised levels.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        bus_start = scl_s & scl_p & sda_p & ~sda_s;
        bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2cs_engine.sv
// Module: bit-level target sequencer. Matches the address, shifts data in
// or out MSB first, handles the 9th-clock acknowledge, holds SCL between
// bytes and keeps the status flags and the interrupt request.
// Assumes DW >= AW + 1 and that software changes direction only while
// the clock is held.
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic [AW-1:0] own_addr,
    input  logic          tx_mode,
    input  logic          ack_send,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dreg,
    output logic          scl_low,
    output logic          sda_low,
    output logic          busy,
    output logic          addr_hit,
    output logic          rw_dir,
    output logic          rx_ack,
    output logic          irq,
    output logic [DW-1:0] rx_byte,
    output logic          rx_load
);
    localparam int            CW   = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    eng_state_t    state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic [DW-1:0] tx_sh;
    logic          acc;

    assign acc     = acc_rd | acc_wr;
    assign rx_byte = sh;

    // Main sequencer: bus events first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx_sh    <= '0;
            scl_low  <= 1'b0;
            sda_low  <= 1'b0;
            busy     <= 1'b0;
            addr_hit <= 1'b0;
            rw_dir   <= 1'b0;
            rx_ack   <= 1'b0;
            irq      <= 1'b0;
            rx_load  <= 1'b0;
        end else begin
            rx_load <= 1'b0;
            if (acc) irq <= 1'b0;
            if (bus_stop) begin
                state    <= ST_IDLE;
                busy     <= 1'b0;
                scl_low  <= 1'b0;
                sda_low  <= 1'b0;
                addr_hit <= 1'b0;
            end else if (bus_start) begin
                state    <= ST_ADDR;
                busy     <= 1'b1;
                cnt      <= '0;
                scl_low  <= 1'b0;
                sda_low  <= 1'b0;
                addr_hit <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[DW-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST) begin
                            if (sh[AW:1] == own_addr) begin
                                rw_dir  <= sh[0];
                                sda_low <= 1'b1;
                                state   <= ST_AACK;
                            end else begin
                                state   <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            sda_low  <= 1'b0;
                            scl_low  <= 1'b1;
                            addr_hit <= 1'b1;
                            irq      <= 1'b1;
                            state    <= ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (acc) begin
                            scl_low  <= 1'b0;
                            addr_hit <= 1'b0;
                            cnt      <= '0;
                            state    <= ST_DATA;
                            if (tx_mode) begin
                                tx_sh   <= acc_wr ? wdata : dreg;
                                sda_low <= acc_wr ? ~wdata[DW-1] : ~dreg[DW-1];
                            end
                        end
                    end
                    ST_DATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[DW-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == LAST) begin
                                state <= ST_DACK;
                                if (tx_mode) begin
                                    sda_low <= 1'b0;
                                end else begin
                                    sda_low <= ~ack_send;
                                    rx_load <= 1'b1;
                                end
                            end else if (tx_mode) begin
                                tx_sh   <= tx_sh << 1;
                                sda_low <= ~tx_sh[DW-2];
                            end
                        end
                    end
                    ST_DACK: begin
                        if (scl_rise && tx_mode) begin
                            rx_ack <= sda_s;
                        end else if (scl_fall) begin
                            sda_low <= 1'b0;
                            irq     <= 1'b1;
                            if (tx_mode ? !rx_ack : sda_low) begin
                                scl_low <= 1'b1;
                                state   <= ST_HOLD;
                            end else begin
                                state   <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: SDA drive only moves while SCL was sampled low.
    assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !$past(scl_s));

    // R1: START raises busy, STOP releases both lines.
    assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> busy);
    assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!scl_low && !sda_low && !busy));

    // R4: clock hold ends only through a data register access, which drops irq.
    assert_hold_release_by_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_low) && !$past(bus_start) && !$past(bus_stop) |-> $past(acc));
    assert_access_clears_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !scl_fall) |=> !irq);

    // R5: leaving the hold leaves the address-hit flag clear.
    assert_hit_clears_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_low) |-> !addr_hit);

    // R3: the address-hit flag only exists inside a busy bus.
    assert_hit_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> busy);

endmodule

// File: rtl/i2c_target_ctrl.sv
// Module: top of the I2C target port. Holds the software-visible registers
// (own address, control, data), builds the status word and connects the
// line synchroniser and the bit engine.
// Assumes single-cycle read and write strobes that are never both active.
module i2c_target_ctrl
    import i2cs_pkg::*;
#(
    parameter int AW        = 7,
    parameter int DW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_pull,
    output logic          sda_pull,
    input  logic [1:0]    cpu_addr,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq
);
    logic [AW-1:0] own_q;
    logic          tx_q, ack_q;
    logic [DW-1:0] data_q;
    logic          scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic          busy, addr_hit, rw_dir, rx_ack, rx_load;
    logic [DW-1:0] rx_byte;
    logic          acc_rd, acc_wr;

    assign acc_rd = cpu_rd & (cpu_addr == OFS_DATA);
    assign acc_wr = cpu_wr & (cpu_addr == OFS_DATA);

    i2cs_line_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2cs_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .own_addr  (own_q),
        .tx_mode   (tx_q),
        .ack_send  (ack_q),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .wdata     (cpu_wdata),
        .dreg      (data_q),
        .scl_low   (scl_pull),
        .sda_low   (sda_pull),
        .busy      (busy),
        .addr_hit  (addr_hit),
        .rw_dir    (rw_dir),
        .rx_ack    (rx_ack),
        .irq       (irq),
        .rx_byte   (rx_byte),
        .rx_load   (rx_load)
    );

    // Software registers; a received byte overrides a same-cycle CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q  <= '0;
            tx_q   <= 1'b0;
            ack_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (cpu_wr && cpu_addr == OFS_OWN)  own_q <= cpu_wdata[AW-1:0];
            if (cpu_wr && cpu_addr == OFS_CTRL) begin
                tx_q  <= cpu_wdata[0];
                ack_q <= cpu_wdata[1];
            end
            if (rx_load)     data_q <= rx_byte;
            else if (acc_wr) data_q <= cpu_wdata;
        end
    end

    // Read multiplexer over the four offsets.
    always_comb begin
        unique case (cpu_addr)
            OFS_OWN:  cpu_rdata = {{(DW-AW){1'b0}}, own_q};
            OFS_CTRL: cpu_rdata = {{(DW-2){1'b0}}, ack_q, tx_q};
            OFS_STAT: cpu_rdata = {{(DW-4){1'b0}}, rx_ack, rw_dir, addr_hit, busy};
            default:  cpu_rdata = data_q;
        endcase
    end

    // R6: a finished incoming byte lands in the data register.
    assert_rx_byte_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> (data_q == $past(rx_byte)));

endmodule

// File: tb/i2c_target_ctrl_test.sv
module i2c_target_ctrl_test;
    localparam int HALF = 20;
    localparam logic [6:0] OWN = 7'h52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b0, m_sda = 1'b0;
    logic       scl_pull, sda_pull, irq;
    logic [1:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic       scl_in, sda_in;
    int         n_chk = 0, n_bad = 0, r9_viol = 0;
    logic       prev_pull = 1'b0, prev_scl = 1'b1;

    assign scl_in = ~(m_scl | scl_pull);
    assign sda_in = ~(m_sda | sda_pull);

    always #5 clk = ~clk;

    i2c_target_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .cpu_addr(cpu_addr),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    // R9 monitor: SDA pull may only move after SCL was low.
    always @(negedge clk) begin
        if (rst_n && (sda_pull !== prev_pull) && prev_scl) r9_viol++;
        prev_pull = sda_pull;
        prev_scl  = scl_in;
    end

    task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

    task automatic wait_scl_high();
        int t = 0;
        while (scl_in !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) check("R4 scl stuck low", 1, 0);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_rd = 1'b1; #1 d = cpu_rdata;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; cyc(HALF); m_scl = 1'b1; cyc(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b1; cyc(HALF); m_scl = 1'b0; wait_scl_high(); cyc(HALF);
        m_sda = 1'b0; cyc(HALF);
    endtask

    task automatic send_bit(input logic b);
        m_sda = ~b; cyc(HALF); m_scl = 1'b0; wait_scl_high(); cyc(HALF);
        m_scl = 1'b1; cyc(HALF);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b0; cyc(HALF); m_scl = 1'b0; wait_scl_high(); cyc(10);
        b = sda_in; cyc(10); m_scl = 1'b1; cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R10 scl_pull", scl_pull, 0);
        check("R10 sda_pull", sda_pull, 0);
        check("R10 irq", irq, 0);
        reg_rd(2'd2, d); check("R10 status", d, 8'h00);
        reg_rd(2'd0, d); check("R10 own addr", d, 8'h00);
        reg_wr(2'd0, {1'b0, OWN});
        reg_rd(2'd0, d); check("R10 own addr readback", d, {1'b0, OWN});
    endtask

    task automatic t_master_write();
        logic ack; logic [7:0] d;
        bus_start();
        reg_rd(2'd2, d); check("R1 busy after start", d[0], 1);
        send_byte({OWN, 1'b0}, ack);
        check("R2 address ack", ack, 0);
        check("R4 hold after address", scl_pull, 1);
        check("R3 irq on match", irq, 1);
        reg_rd(2'd2, d); check("R3 status hit/dir/busy", d[2:0], 3'b011);
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd3, d);
        check("R4 release on dummy read", scl_pull, 0);
        check("R4 irq cleared", irq, 0);
        reg_rd(2'd2, d); check("R5 hit cleared", d[1], 0);
        send_byte(8'hA5, ack);
        check("R6 ack on byte", ack, 0);
        check("R8 irq on byte", irq, 1);
        check("R4 hold after byte", scl_pull, 1);
        reg_rd(2'd2, d); check("R8 hit reads 0", d[1], 0);
        reg_wr(2'd1, 8'h02);
        reg_rd(2'd3, d); check("R6 byte stored", d, 8'hA5);
        check("R4 release after byte", scl_pull, 0);
        send_byte(8'h3C, ack);
        check("R6 refused byte", ack, 1);
        check("R6 no hold after refusal", scl_pull, 0);
        reg_rd(2'd3, d); check("R6 second byte stored", d, 8'h3C);
        bus_stop();
        reg_rd(2'd2, d); check("R1 busy cleared", d[0], 0);
        check("R1 lines released", {scl_pull, sda_pull}, 2'b00);
    endtask

    task automatic t_master_read();
        logic ack; logic [7:0] d, v;
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        check("R2 address ack read", ack, 0);
        reg_rd(2'd2, d); check("R3 dir read", d[2:0], 3'b111);
        reg_wr(2'd1, 8'h01);
        reg_wr(2'd3, 8'hC3);
        check("R4 release on write", scl_pull, 0);
        recv_byte(v); check("R7 first byte", v, 8'hC3);
        send_bit(1'b0);
        check("R7 hold after ack", scl_pull, 1);
        check("R8 irq tx byte", irq, 1);
        reg_rd(2'd2, d); check("R7 rx ack 0", d[3], 0);
        reg_wr(2'd3, 8'h5A);
        recv_byte(v); check("R7 second byte", v, 8'h5A);
        send_bit(1'b1);
        check("R7 no hold on nack", scl_pull, 0);
        check("R7 sda released", sda_pull, 0);
        reg_rd(2'd2, d); check("R7 rx ack 1", d[3], 1);
        bus_stop();
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd3, d);
    endtask

    task automatic t_mismatch();
        logic ack; logic [7:0] d;
        bus_start();
        send_byte({7'h33, 1'b0}, ack);
        check("R2 no ack on mismatch", ack, 1);
        check("R2 no irq on mismatch", irq, 0);
        check("R2 no hold on mismatch", scl_pull, 0);
        send_byte(8'h00, ack);
        check("R2 bus ignored", ack, 1);
        reg_rd(2'd2, d); check("R2 hit stays 0", d[1], 0);
        bus_stop();
        reg_rd(2'd2, d); check("R1 busy cleared after mismatch", d[0], 0);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_master_write();
        t_master_read();
        t_mismatch();
        check("R9 sda moved with scl high", r9_viol, 0);
        finish_run();
    end
endmodule